// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked host and an external asynchronous static RAM of 262,144 sixteen-bit words. The host raises a request together with a read/write flag, an 18-bit word address, write data and a two-bit lane mask. The controller turns that request into the control pin sequence the RAM needs, then pulses an acknowledge for one clock. The RAM has two chip enables of opposite polarity, separate write and output enables, one byte enable per lane and a shared tri-state data bus.

Every access has three phases. A setup clock selects the RAM and presents the address and lanes. A strobe phase follows, held for a whole number of clocks that covers the RAM's access time. A hold clock closes the access. The lane mask applies to reads and to writes. Between accesses the RAM is deselected, so it drops into its own low-power state whenever the host is quiet.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While `rst` is high, and at the first clock after it, `ram_ce1_n`=1, `ram_ce2`=0, `ram_we_n`=1, `ram_oe_n`=1 and `ack`=0. The controller does not drive `ram_dq`.
- R2: Outside an access the RAM is deselected (`ram_ce1_n`=1, `ram_ce2`=0). The clock after each `ack` is such a deselected clock.
- R3: A write (`wr`=1) selects the RAM (`ram_ce1_n`=0, `ram_ce2`=1) and pulls `ram_we_n` low, with `ram_oe_n` held high. `ram_lb_n` is low exactly when `mask[0]`=1 and gates `ram_dq[7:0]`. `ram_ub_n` is low exactly when `mask[1]`=1 and gates `ram_dq[15:8]`.
- R4: A read (`wr`=0) selects the RAM and pulls `ram_oe_n` low, with `ram_we_n` held high. The byte enables follow the mask as in R3.
- R5: Each write or output enable strobe stays low for exactly WAIT consecutive clocks, where WAIT = ceil(ACCESS_PS / CLK_PS). The default is 24.
- R6: The RAM is selected, and the address and byte enables are unchanged, in the clock before `ram_we_n` falls and in the clock in which it rises.
- R7: `ram_we_n` and `ram_oe_n` are never low together. The controller drives `ram_dq` only during a write access. `ram_oe_n` falls at least two clocks after `ram_we_n` was last low.
- R8: At `ack` of a read, `rdata` holds the RAM data for lanes whose mask bit is 1. Lanes whose mask bit is 0 read as zero.
- R9: A request is taken when `req` is high at a rising edge in idle, and its inputs are captured at that edge. `ack` is high for exactly one clock, WAIT+2 rising edges after that edge, counting that edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Host request, held until ack |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| mask | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Masked read data, valid at ack |
| ram_ce1_n | output | 1 | Chip enable, active low |
| ram_ce2 | output | 1 | Chip enable, active high |
| ram_we_n | output | 1 | Write enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_lb_n | output | 1 | Low byte enable, active low |
| ram_ub_n | output | 1 | High byte enable, active low |
| ram_addr | output | ADDR_W | RAM word address |
| ram_dq | inout | 16 | Bidirectional RAM data |

## Verification
The assertions assume the host holds `req` and its fields steady until `ack` and drops `req` in the `ack` clock, so that no second access starts from a stale request. They also assume the RAM drives `ram_dq` only while it is selected with `ram_oe_n` low. The bench keeps to this: it changes requests only at falling edges, lowers `req` as soon as it sees `ack`, and uses a RAM model that follows that output rule. The model puts a filler byte on disabled lanes, so a read that ignores its mask shows up at once.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W    = 18,
  parameter int CLK_PS    = 5000,
  parameter int ACCESS_PS = 120000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [1:0]        mask,
  output logic              ack,
  output logic [15:0]       rdata,
  output logic              ram_ce1_n,
  output logic              ram_ce2,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic              ram_lb_n,
  output logic              ram_ub_n,
  output logic [ADDR_W-1:0] ram_addr,
  inout  wire  [15:0]       ram_dq
);
  localparam int WAIT_RAW = (ACCESS_PS + CLK_PS - 1) / CLK_PS;
  localparam int WAIT     = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int CW       = $clog2(WAIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} state_t;

  state_t            st;
  logic [CW-1:0]     cnt;
  logic              wr_q;
  logic [ADDR_W-1:0] a_q;
  logic [15:0]       wd_q;
  logic [1:0]        m_q;
  logic [15:0]       rd_q;
  logic              sel, drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      wr_q <= 1'b0;
      a_q  <= '0;
      wd_q <= '0;
      m_q  <= '0;
      rd_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          wr_q <= wr;
          a_q  <= addr;
          wd_q <= wdata;
          m_q  <= mask;
          st   <= S_SETUP;
        end
        S_SETUP: begin
          cnt <= '0;
          st  <= S_STROBE;
        end
        S_STROBE: if (cnt == CW'(WAIT - 1)) begin
          st <= S_HOLD;
          if (!wr_q)
            rd_q <= {m_q[1] ? ram_dq[15:8] : 8'h00, m_q[0] ? ram_dq[7:0] : 8'h00};
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sel       = (st != S_IDLE);
  assign drive     = sel && wr_q;
  assign ram_ce1_n = !sel;
  assign ram_ce2   = sel;
  assign ram_we_n  = !(st == S_STROBE && wr_q);
  assign ram_oe_n  = !(st == S_STROBE && !wr_q);
  assign ram_lb_n  = !(sel && m_q[0]);
  assign ram_ub_n  = !(sel && m_q[1]);
  assign ram_addr  = a_q;
  assign ram_dq    = drive ? wd_q : 16'bz;
  assign ack       = (st == S_HOLD);
  assign rdata     = rd_q;

  logic [CW-1:0] lo_run;
  logic          strb_lo;
  assign strb_lo = !ram_we_n || !ram_oe_n;

  always_ff @(posedge clk) begin
    if (rst)          lo_run <= '0;
    else if (strb_lo) lo_run <= lo_run + 1'b1;
    else              lo_run <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk) $past(rst) |-> ram_ce1_n && !ram_ce2 && ram_we_n && ram_oe_n && !ack);
  p_deselect_after_ack_r2: assert property (@(posedge clk) disable iff (rst) ack |=> ram_ce1_n && !ram_ce2);
  p_write_selected_r3: assert property (@(posedge clk) disable iff (rst) !ram_we_n |-> !ram_ce1_n && ram_ce2 && ram_oe_n);
  p_read_selected_r4: assert property (@(posedge clk) disable iff (rst) !ram_oe_n |-> !ram_ce1_n && ram_ce2 && ram_we_n);
  p_strobe_bound_r5: assert property (@(posedge clk) disable iff (rst) strb_lo |-> lo_run < CW'(WAIT));
  p_strobe_width_r5: assert property (@(posedge clk) disable iff (rst) (!strb_lo && $past(strb_lo)) |-> lo_run == CW'(WAIT));
  p_we_setup_r6: assert property (@(posedge clk) disable iff (rst) $fell(ram_we_n) |-> $past(!ram_ce1_n) && $stable(ram_addr) && $stable({ram_lb_n, ram_ub_n}));
  p_we_hold_r6: assert property (@(posedge clk) disable iff (rst) $rose(ram_we_n) |-> !ram_ce1_n && $stable(ram_addr) && $stable({ram_lb_n, ram_ub_n}));
  p_no_contention_r7: assert property (@(posedge clk) disable iff (rst) !ram_oe_n |-> !drive);
  p_turnaround_r7: assert property (@(posedge clk) disable iff (rst) $fell(ram_oe_n) |-> $past(ram_we_n) && $past(!drive));
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);
endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;
  localparam int ADDR_W = 18, CLK_PS = 5000, ACCESS_PS = 120000;
  localparam int EXP_WAIT = (ACCESS_PS + CLK_PS - 1) / CLK_PS;

  logic clk = 0, rst = 1, req = 0, wr = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0] mask = '0;
  logic ack, ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n;
  logic [15:0] rdata;
  logic [ADDR_W-1:0] ram_addr;
  wire [15:0] ram_dq;

  always #2500ps clk = ~clk;

  sram_lane_ctrl #(.ADDR_W(ADDR_W), .CLK_PS(CLK_PS), .ACCESS_PS(ACCESS_PS)) u_sram_lane_ctrl (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata), .mask(mask),
    .ack(ack), .rdata(rdata), .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .ram_lb_n(ram_lb_n), .ram_ub_n(ram_ub_n), .ram_addr(ram_addr), .ram_dq(ram_dq));

  logic [15:0] mem [256];
  logic model_sel;
  assign model_sel = !ram_ce1_n && ram_ce2;
  assign ram_dq = (model_sel && !ram_oe_n && ram_we_n) ?
    {ram_ub_n ? 8'hA5 : mem[ram_addr[7:0]][15:8], ram_lb_n ? 8'hA5 : mem[ram_addr[7:0]][7:0]} : 16'bz;

  always @(posedge clk)
    if (model_sel && !ram_we_n) begin
      if (!ram_lb_n) mem[ram_addr[7:0]][7:0]  <= ram_dq[7:0];
      if (!ram_ub_n) mem[ram_addr[7:0]][15:8] <= ram_dq[15:8];
    end

  int errors = 0, checks = 0;
  int run = 0, last_width = -1, since_wr = 100, last_gap = -1, both_low = 0, sh_bad = 0;
  logic strb_lb_n, strb_ub_n, strb_sel;
  logic p_we = 1, p_oe = 1, p_sel = 0;
  logic [ADDR_W-1:0] p_addr = '0;
  logic [1:0] p_lanes = 2'b11;
  bit done = 0;

  always @(negedge clk) if (!rst) begin
    if (!ram_we_n && !ram_oe_n) both_low++;
    if (!ram_we_n || !ram_oe_n) begin
      run++;
      strb_lb_n = ram_lb_n; strb_ub_n = ram_ub_n; strb_sel = model_sel;
    end else if (run != 0) begin
      last_width = run; run = 0;
    end
    if (p_we && !ram_we_n && !(p_sel && p_addr == ram_addr && p_lanes == {ram_ub_n, ram_lb_n})) sh_bad++;
    if (!p_we && ram_we_n && !(model_sel && p_addr == ram_addr && p_lanes == {ram_ub_n, ram_lb_n})) sh_bad++;
    if (p_oe && !ram_oe_n) last_gap = since_wr;
    if (!ram_we_n) since_wr = 0; else if (since_wr < 100) since_wr++;
    p_we = ram_we_n; p_oe = ram_oe_n; p_sel = model_sel; p_addr = ram_addr; p_lanes = {ram_ub_n, ram_lb_n};
  end

  task automatic check(input bit ok, input string req_id, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_id, what, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic [1:0] m);
    int n = 0;
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d; mask = m;
    do begin @(negedge clk); n++; end while (!ack && n < 200);
    check(n == EXP_WAIT + 2, "R9", "ack latency", n, EXP_WAIT + 2);
    req = 0;
    @(negedge clk);
    check(!ack && ram_ce1_n && !ram_ce2, "R2", "deselect after ack", {ack, ram_ce1_n, ram_ce2}, 3'b010);
    check(last_width == EXP_WAIT, "R5", "strobe width", last_width, EXP_WAIT);
    check(strb_sel && strb_lb_n == !m[0] && strb_ub_n == !m[1], w ? "R3" : "R4", "select and lanes",
          {strb_sel, strb_ub_n, strb_lb_n}, {1'b1, !m[1], !m[0]});
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(ram_ce1_n && !ram_ce2 && ram_we_n && ram_oe_n && !ack, "R1", "reset outputs",
          {ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, ack}, 5'b10110);
    rst = 0;
    @(negedge clk);
    check(ram_ce1_n && !ram_ce2 && ram_we_n && ram_oe_n && !ack, "R1", "first idle clock",
          {ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, ack}, 5'b10110);
  endtask

  task automatic t_write(input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic [1:0] m);
    access(1, a, d, m);
  endtask

  task automatic t_read(input logic [ADDR_W-1:0] a, input logic [1:0] m, input logic [15:0] exp, input bit after_wr);
    access(0, a, 16'h0, m);
    check(rdata == exp, "R8", "masked read data", rdata, exp);
    if (after_wr) check(last_gap >= 2, "R7", "turnaround gap", last_gap, 2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    t_reset();
    t_write(18'h00012, 16'hBEEF, 2'b11);
    t_read (18'h00012, 2'b11, 16'hBEEF, 1);
    t_write(18'h00012, 16'h1122, 2'b01);
    t_read (18'h00012, 2'b11, 16'hBE22, 1);
    t_write(18'h00012, 16'h3344, 2'b10);
    t_read (18'h00012, 2'b01, 16'h0022, 1);
    t_read (18'h00012, 2'b10, 16'h3300, 0);
    t_read (18'h00012, 2'b00, 16'h0000, 0);
    t_write(18'h3FFFF, 16'hA5C3, 2'b11);
    t_read (18'h3FFFF, 2'b11, 16'hA5C3, 1);
    check(both_low == 0, "R7", "strobes overlap count", both_low, 0);
    check(sh_bad == 0, "R6", "write setup/hold violations", sh_bad, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule